// File: doc/BRIEF.md
# Algorithmic Unlock Byte Stream Generator

This block produces a fixed 17-byte unlock stream without storing it. Two 8-bit pattern registers are rotated and swapped at each step. A byte register is shifted, masked and merged with one of them. Together they rebuild the body of the stream, which is made of two interleaved 4-bit shift-register patterns. Two leading bytes come before the body and two copies of a trailer byte follow it.

A consumer takes the stream over a valid/ready handshake. A byte moves only on a cycle where both valid and ready are high. A start pulse loads the initial register values and begins the stream. When the last trailer byte has moved, the done flag rises and stays high until the next start.

Top module: `unlock_stream_gen`

## Requirements
- R1: Right after reset, valid_o and done_o are both 0.
- R2: A start pulse while idle or done reloads the registers. On the next cycle valid_o is 1 and data_o is 0xFF. The byte after that is 0x00.
- R3: A full run delivers exactly 17 bytes: 0xFF, 0x00, 0xFF, 0x77, 0xB3, 0x51, 0xA8, 0xD4, 0x62, 0x39, 0x9C, 0x46, 0x2B, 0x15, 0x8A, 0xCD, 0xCD.
- R4: On each body transfer, the new pattern register A takes the old value of register B. The new register B takes the old register A rotated left by one bit. The registers start at A=0x90 and B=0xEA.
- R5: On each body transfer, the next byte is formed in three steps. The current byte is shifted right by one. Its bit 3 is then cleared. Finally the new register B, masked with 0x88, is ORed in.
- R6: When the updated byte equals 0x4D, the body ends and 0x4D is not emitted. The next two bytes are 0xCD.
- R7: While valid_o is 1 and ready_i is 0, data_o and valid_o hold and the stream does not advance.
- R8: done_o rises on the cycle after the second 0xCD transfers. From then on valid_o is 0, and valid_o and done_o are never both 1.
- R9: A start pulse while a stream is in progress has no effect. The stream continues with the same next byte.
- R10: A start pulse after done_o is high clears done_o and reproduces the full stream from 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new stream when idle or done |
| ready_i | input | 1 | Consumer can take a byte this cycle |
| data_o | output | 8 | Current stream byte |
| valid_o | output | 1 | data_o holds a byte to transfer |
| done_o | output | 1 | The full stream has been transferred |

## Verification
The hold assertion assumes that a consumer may lower ready at any time. It also assumes that start is only a request, honoured only when no stream is active. The bench therefore asserts start during stalls and in the middle of a stream, and varies ready from cycle to cycle. The start assertion assumes start is not held high across the cycle in which valid rises. The bench drives start as single-cycle pulses, away from the clock edge.

// File: rtl/unlock_pkg.sv
// Package: shared state encoding for the unlock stream generator.
// Assumes a single stream source per instance.
package unlock_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEADC = 3'd1,
        ST_LEADZ = 3'd2,
        ST_BODY  = 3'd3,
        ST_TAIL  = 3'd4,
        ST_FIN   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/unlock_pattern_reg.sv
// Module: pair of pattern registers updated by rotate-and-swap.
// What it does: on step, A <= B and B <= rotl(A,1); on load, both take their
// initial values. Exposes the next B value combinationally for the byte merge.
// Assumes load and step are never high together (controller guarantees it).
module unlock_pattern_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] A_INIT = 8'h90,
    parameter logic [W-1:0] B_INIT = 8'hEA
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] b_next
);
    logic [W-1:0] a_q, b_q;

    // Next B value: A rotated left by one position.
    always_comb b_next = {a_q[W-2:0], a_q[W-1]};

    // Register update: reset/load to init, swap-and-rotate on step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            a_q <= A_INIT;
            b_q <= B_INIT;
        end else if (step) begin
            a_q <= b_q;
            b_q <= b_next;
        end
    end

    // R4: A always takes the previous B on a step
    assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (a_q == $past(b_q)));
endmodule

// File: rtl/unlock_byte_reg.sv
// Module: stream byte register with shift, clear and masked merge.
// What it does: next = ((c >> 1) with bit CLR_BIT cleared) | (b_next & MASK);
// flags when that next value equals the stop code.
// Assumes b_next is the pattern value that becomes current on the same step.
module unlock_byte_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] C_INIT  = 8'hFF,
    parameter logic [W-1:0] MASK    = 8'h88,
    parameter int           CLR_BIT = 3,
    parameter logic [W-1:0] STOP    = 8'h4D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] b_next,
    output logic [W-1:0] c_q,
    output logic         stop_hit
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << CLR_BIT);

    logic [W-1:0] c_next;

    // Combinational next byte and termination compare.
    always_comb begin
        c_next   = ({1'b0, c_q[W-1:1]} & KEEP) | (b_next & MASK);
        stop_hit = (c_next == STOP);
    end

    // Byte register: reset/load to init, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) c_q <= C_INIT;
        else if (step)      c_q <= c_next;
    end

    // R5: the bit shifted into the MSB position comes only from the mask merge
    assert_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !b_next[W-1]) |=> !c_q[W-1]);
endmodule

// File: rtl/unlock_seq_ctrl.sv
// Module: stream sequencer.
// What it does: walks lead bytes, body, trailer repeats and finish; advances
// only on valid&ready; accepts start only when idle or finished.
// Assumes stop_hit is meaningful only during a body transfer.
module unlock_seq_ctrl
    import unlock_pkg::*;
#(
    parameter int TAIL_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ready,
    input  logic       stop_hit,
    output logic       load,
    output logic       step,
    output logic       valid,
    output logic       done,
    output seq_state_t state
);
    localparam int CNT_W = (TAIL_N > 1) ? $clog2(TAIL_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TAIL_N - 1);

    seq_state_t   st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic         xfer;

    // Handshake decode and control strobes.
    always_comb begin
        valid = (st_q == ST_LEADC) || (st_q == ST_LEADZ) ||
                (st_q == ST_BODY)  || (st_q == ST_TAIL);
        done  = (st_q == ST_FIN);
        xfer  = valid && ready;
        load  = start && ((st_q == ST_IDLE) || (st_q == ST_FIN));
        step  = xfer && (st_q == ST_BODY);
        state = st_q;
    end

    // Next-state logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE, ST_FIN: if (load) begin
                st_d  = ST_LEADC;
                cnt_d = '0;
            end
            ST_LEADC: if (xfer) st_d = ST_LEADZ;
            ST_LEADZ: if (xfer) st_d = ST_BODY;
            ST_BODY:  if (xfer && stop_hit) st_d = ST_TAIL;
            ST_TAIL:  if (xfer) begin
                if (cnt_q == LAST) st_d = ST_FIN;
                else               cnt_d = cnt_q + 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and trailer counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // R8: finish is reached only from the trailer phase
    assert_fin_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(st_q) == ST_TAIL));
    // R9: a start in the middle of a stream never reloads
    assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !load);
endmodule

// File: rtl/unlock_stream_gen.sv
// Module: top of the algorithmic unlock byte stream generator.
// What it does: joins the pattern pair, the byte register and the sequencer,
// and selects the output byte per phase.
// Assumes the consumer follows valid/ready: a byte moves when both are high.
module unlock_stream_gen
    import unlock_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] A_INIT  = 8'h90,
    parameter logic [W-1:0] B_INIT  = 8'hEA,
    parameter logic [W-1:0] C_INIT  = 8'hFF,
    parameter logic [W-1:0] MASK    = 8'h88,
    parameter int           CLR_BIT = 3,
    parameter logic [W-1:0] STOP    = 8'h4D,
    parameter logic [W-1:0] LEAD2   = 8'h00,
    parameter logic [W-1:0] TRAIL   = 8'hCD,
    parameter int           TAIL_N  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         ready_i,
    output logic [W-1:0] data_o,
    output logic         valid_o,
    output logic         done_o
);
    logic         load, step, stop_hit;
    logic [W-1:0] b_next, c_q;
    seq_state_t   state;

    unlock_pattern_reg #(.W(W), .A_INIT(A_INIT), .B_INIT(B_INIT)) u_pat (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .b_next(b_next)
    );

    unlock_byte_reg #(.W(W), .C_INIT(C_INIT), .MASK(MASK),
                      .CLR_BIT(CLR_BIT), .STOP(STOP)) u_byte (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .b_next(b_next), .c_q(c_q), .stop_hit(stop_hit)
    );

    unlock_seq_ctrl #(.TAIL_N(TAIL_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_i), .ready(ready_i),
        .stop_hit(stop_hit), .load(load), .step(step),
        .valid(valid_o), .done(done_o), .state(state)
    );

    // Output byte selection by phase.
    always_comb begin
        unique case (state)
            ST_LEADZ: data_o = LEAD2;
            ST_TAIL:  data_o = TRAIL;
            ST_LEADC, ST_BODY: data_o = c_q;
            default:  data_o = '0;
        endcase
    end

    // R7: a stalled byte holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
    // R8: never valid while done
    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && done_o));
    // R8: done rises right after a trailer byte transfer
    assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(valid_o && ready_i && data_o == TRAIL));
    // R2: accepted start gives the initial byte next cycle
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_o) |=> (valid_o && data_o == C_INIT));
    // R6: the stop code is never emitted
    assert_no_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (data_o != STOP));
endmodule

// File: tb/tb_unlock_stream_gen.sv
module tb_unlock_stream_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       ready_i = 1'b0;
    logic [7:0] data_o;
    logic       valid_o;
    logic       done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    localparam int N = 17;
    localparam logic [7:0] EXP [N] = '{
        8'hFF, 8'h00, 8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
        8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hCD};

    always #5 clk = ~clk;

    unlock_stream_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
        .data_o(data_o), .valid_o(valid_o), .done_o(done_o));

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Walk one stream. stall_mode: 0 none, 1 stall every odd byte.
    // mid_start: index at which a start pulse is asserted during a stall.
    task automatic run_stream(input int stall_mode, input int mid_start,
                              input string tag);
        pulse_start();
        chk({tag, " R2 valid"}, valid_o, 1);
        for (int i = 0; i < N; i++) begin
            if ((stall_mode == 1 && (i % 2) == 1) || i == mid_start) begin
                ready_i = 1'b0;
                if (i == mid_start) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(i == mid_start ? "R9 start ignored" : "R7 hold valid",
                    valid_o, 1);
                chk(i == mid_start ? "R9 start ignored" : "R7 hold data",
                    data_o, EXP[i]);
            end
            ready_i = 1'b1;
            chk(i < 2 ? "R2 lead byte" : (i >= 15 ? "R6 trailer" :
                "R3 R4 R5 body"), data_o, EXP[i]);
            @(negedge clk);
        end
        ready_i = 1'b0;
        chk("R8 done", done_o, 1);
        chk("R8 valid low", valid_o, 0);
        @(negedge clk);
        chk("R8 done held", done_o, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", valid_o, 0);
        chk("R1 done", done_o, 0);

        // Ready with no stream: nothing starts.
        ready_i = 1'b1;
        @(negedge clk);
        chk("R1 idle", valid_o, 0);
        ready_i = 1'b0;

        run_stream(0, -1, "run1");
        run_stream(1, -1, "R10 restart");
        run_stream(0, 7, "run3");

        // Stop right after the first lead byte: start while mid-stream.
        pulse_start();
        ready_i = 1'b1;
        @(negedge clk);
        ready_i = 1'b0;
        chk("R2 second lead", data_o, 8'h00);
        pulse_start();
        chk("R9 no restart", data_o, 8'h00);

        // Reset mid-stream clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mid valid", valid_o, 0);
        chk("R1 reset mid done", done_o, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule